// File: doc/BRIEF.md
# Beam-Synchronised Display List Coprocessor

This block is a small coprocessor that walks a list of two-word instructions held in memory and acts on them in step with the raster beam. It reads each instruction word through a memory port. An external arbiter owns that port and grants it one bus slot at a time. Two instruction kinds exist.

A MOVE places a 16-bit immediate value on an internal register-write bus, at the register index named in its first word. A WAIT stalls the coprocessor until the live vertical and horizontal beam counters reach a target position. The WAIT compares only the bits that its mask word enables.

A host programs two list-start addresses. Each address is written in two halves. The host can also fire either of two jump strobes, which redirect execution to the matching start address. At every frame-start pulse, execution begins again at the first list. A fixed word pair marks the end of a list and parks the coprocessor until the next restart. A global enable input gates every memory request.

Top module: `dlist_cop`

## Requirements
- R1: After reset the block issues no memory request and no register write until a frame-start pulse or a jump strobe arrives.
- R2: A first word with bit 0 = 0 is a MOVE. Its second word is written as data to register index word1[8:1]. `reg_we` pulses for exactly one cycle, in the cycle after the granted slot that fetched the second word.
- R3: A MOVE consumes two granted slots. A WAIT consumes three: two fetch slots, then one wake slot taken after its condition is met. With every slot granted, a MOVE placed right after a WAIT writes 4 cycles after the first cycle in which the beam satisfies the WAIT.
- R4: A first word with bit 0 = 1 is a WAIT. Its target is vertical = word1[15:8] and horizontal = {word1[7:1],0}. The mask word enables vertical bits [15:8] and horizontal bits [7:1]; horizontal bit 0 is never compared. The WAIT stalls until {vpos,hpos}&M >= target&M as an unsigned 16-bit comparison. No request is issued while it stalls.
- R5: Words are fetched only in cycles where `mem_req` and `mem_gnt` are both high. The address holds while a request is not granted, and it advances by 2 for each fetched word.
- R6: The pair 16'hFFFF followed by 16'hFFFE ends the list. No further request is issued until a frame start or a jump strobe.
- R7: A frame-start pulse, from any state, reloads the fetch address from location register 1. Fetching starts in the next cycle.
- R8: Host select 4 (jump 1) reloads from location 1, and select 5 (jump 2) reloads from location 2. A frame start in the same cycle wins over either strobe.
- R9: Host select 0 and select 2 write location 1 and location 2 bits [23:16] from wdata[7:0]. Select 1 and select 3 write bits [15:0], with bit 0 forced to 0. These writes never move the current fetch address.
- R10: While `en` is low, no request is issued and execution holds its place. When `en` rises, execution resumes from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global fetch enable |
| frame_start | input | 1 | One-cycle pulse at frame start |
| vpos | input | 8 | Live vertical beam counter |
| hpos | input | 8 | Live horizontal beam counter |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host target: 0/1 loc1 high/low, 2/3 loc2 high/low, 4/5 jump 1/2 |
| host_wdata | input | 16 | Host write data |
| mem_req | output | 1 | Request for a memory slot |
| mem_addr | output | 24 | Byte address of the word being fetched |
| mem_gnt | input | 1 | Slot granted this cycle; read data valid |
| mem_rdata | input | 16 | Read data |
| reg_we | output | 1 | Register-bus write pulse |
| reg_addr | output | 8 | Register index |
| reg_wdata | output | 16 | Register data |

## Verification
The embedded assertions check these on every cycle:
- no request while disabled;
- every register write follows a granted slot and never lasts two cycles;
- the address holds through an ungranted request;
- the address stays even;
- frame start and jump 2 land on the right location register.

The following need the bench's scenarios:
- the exact cycle at which a WAIT releases for each target and mask in a sweep;
- the slot count per instruction kind;
- the parking at the end marker;
- the priority of frame start over a strobe;
- the fact that location writes leave a running list untouched.

// File: rtl/dlist_cop.sv
module dlist_cop #(
  parameter int PC_W = 24,
  parameter int RA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              frame_start,
  input  logic [7:0]        vpos,
  input  logic [7:0]        hpos,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [15:0]       host_wdata,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  input  logic              mem_gnt,
  input  logic [15:0]       mem_rdata,
  output logic              reg_we,
  output logic [RA_W-1:0]   reg_addr,
  output logic [15:0]       reg_wdata
);
  localparam int HI_W = PC_W - 16;
  localparam logic [2:0] SEL_L1H = 3'd0, SEL_L1L = 3'd1, SEL_L2H = 3'd2,
                         SEL_L2L = 3'd3, SEL_J1 = 3'd4, SEL_J2 = 3'd5;

  typedef enum logic [2:0] {S_STOP, S_F1, S_F2, S_WAIT, S_WAKE} st_t;

  st_t             st;
  logic [PC_W-1:0] pc, loc1, loc2;
  logic [15:0]     ir;
  logic [15:1]     msk;
  logic            jump1, jump2, slot, hit, is_end;
  logic [15:0]     cmp_mask, cur_pos, tgt_pos;

  assign jump1    = host_we && host_sel == SEL_J1;
  assign jump2    = host_we && host_sel == SEL_J2;
  assign mem_req  = en && (st == S_F1 || st == S_F2 || st == S_WAKE);
  assign mem_addr = pc;
  assign slot     = mem_req && mem_gnt;

  assign cmp_mask = {msk[15:8], msk[7:1], 1'b0};
  assign cur_pos  = {vpos, hpos} & cmp_mask;
  assign tgt_pos  = {ir[15:1], 1'b0} & cmp_mask;
  assign hit      = cur_pos >= tgt_pos;
  assign is_end   = ir == 16'hFFFF && mem_rdata == 16'hFFFE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc1 <= '0;
      loc2 <= '0;
    end else if (host_we) begin
      case (host_sel)
        SEL_L1H: loc1[PC_W-1:16] <= host_wdata[HI_W-1:0];
        SEL_L1L: loc1[15:0]      <= {host_wdata[15:1], 1'b0};
        SEL_L2H: loc2[PC_W-1:16] <= host_wdata[HI_W-1:0];
        SEL_L2L: loc2[15:0]      <= {host_wdata[15:1], 1'b0};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_STOP;
      pc        <= '0;
      ir        <= '0;
      msk       <= '0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (frame_start) begin
        pc <= loc1;
        st <= S_F1;
      end else if (jump1) begin
        pc <= loc1;
        st <= S_F1;
      end else if (jump2) begin
        pc <= loc2;
        st <= S_F1;
      end else begin
        case (st)
          S_F1: if (slot) begin
            ir <= mem_rdata;
            pc <= pc + PC_W'(2);
            st <= S_F2;
          end
          S_F2: if (slot) begin
            pc <= pc + PC_W'(2);
            if (!ir[0]) begin
              reg_we    <= 1'b1;
              reg_addr  <= ir[RA_W:1];
              reg_wdata <= mem_rdata;
              st        <= S_F1;
            end else if (is_end) begin
              st <= S_STOP;
            end else begin
              msk <= mem_rdata[15:1];
              st  <= S_WAIT;
            end
          end
          S_WAIT: if (hit) st <= S_WAKE;
          S_WAKE: if (slot) st <= S_F1;
          default: ;
        endcase
      end
    end
  end

  a_r10_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mem_req);

  a_r2_write_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(mem_req && mem_gnt));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !frame_start && !jump1 && !jump2) |=> $stable(mem_addr));

  a_r7_frame_reload: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> mem_addr == $past(loc1));

  a_r8_jump2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (jump2 && !frame_start) |=> mem_addr == $past(loc2));

  a_r9_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
endmodule

// File: tb/dlist_cop_test.sv
module dlist_cop_test;
  localparam int CLK_P = 10;
  localparam int HT    = 40;
  localparam logic [2:0] L1H = 3'd0, L1L = 3'd1, L2H = 3'd2, L2L = 3'd3, J1 = 3'd4, J2 = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, frame_start = 1'b0;
  logic [7:0] vpos = '0, hpos = '0;
  logic host_we = 1'b0;
  logic [2:0] host_sel = '0;
  logic [15:0] host_wdata = '0;
  logic mem_req, mem_gnt, reg_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata, reg_wdata;
  logic [7:0] reg_addr;
  logic gpat = 1'b0;
  logic [15:0] mem [0:127];

  assign mem_gnt   = mem_req & gpat;
  assign mem_rdata = mem[mem_addr[7:1]];

  always #(CLK_P/2) clk = ~clk;

  dlist_cop uut (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
    .vpos(vpos), .hpos(hpos), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  int k = 0, P = 1, nchk = 0, nfail = 0, nw = 0, ngr = 0, nreq = 0, gb = 0;
  int w_k [8];
  logic [7:0] w_a [8];
  logic [15:0] w_d [8];
  logic [23:0] fa;
  bit fa_set = 0, en_nxt = 0;

  task automatic step(bit fs, bit hw, logic [2:0] hs, logic [15:0] hd);
    @(negedge clk);
    frame_start = fs; host_we = hw; host_sel = hs; host_wdata = hd; en = en_nxt;
    hpos = 8'(k % HT); vpos = 8'(k / HT); gpat = (k % P) == 0;
    #(CLK_P/4);
    if (reg_we && nw < 8) begin
      w_k[nw] = k; w_a[nw] = reg_addr; w_d[nw] = reg_wdata; nw++;
    end
    if (mem_req) begin
      nreq++;
      if (!fa_set) begin fa = mem_addr; fa_set = 1; end
    end
    if (mem_req && mem_gnt) begin
      ngr++;
      if (nw == 0) gb++;
    end
    k++;
  endtask

  task automatic clr();
    nw = 0; ngr = 0; nreq = 0; gb = 0; fa_set = 0;
  endtask

  task automatic idle(int n);
    repeat (n) step(1'b0, 1'b0, 3'd0, 16'd0);
  endtask

  task automatic hwr(logic [2:0] s, logic [15:0] d);
    step(1'b0, 1'b1, s, d);
  endtask

  task automatic frame(int n);
    k = 0; clr();
    step(1'b1, 1'b0, 3'd0, 16'd0);
    idle(n - 1);
  endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit hitf(int kk, int tv, int th, int vm, int hm);
    logic [15:0] m, c, t;
    m = {8'(vm), 8'(hm) & 8'hFE};
    c = {8'(kk / HT), 8'(kk % HT)} & m;
    t = {8'(tv), 8'(th)} & m;
    return c >= t;
  endfunction

  initial begin
    #(CLK_P * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    mem[7'h10] = 16'h000A; mem[7'h11] = 16'h1234;
    mem[7'h12] = 16'h014A; mem[7'h13] = 16'hABCD;
    mem[7'h14] = 16'hFFFF; mem[7'h15] = 16'hFFFE;
    mem[7'h22] = 16'h0006;
    mem[7'h24] = 16'hFFFF; mem[7'h25] = 16'hFFFE;
    mem[7'h40] = 16'h000E; mem[7'h41] = 16'h00BB;
    mem[7'h42] = 16'hFFFF; mem[7'h43] = 16'hFFFE;
    mem[7'h60] = 16'hC801; mem[7'h61] = 16'hFFFE;
    mem[7'h62] = 16'h0012; mem[7'h63] = 16'h0999;
    mem[7'h64] = 16'hFFFF; mem[7'h65] = 16'hFFFE;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en_nxt = 1;
    clr();
    idle(10);
    chk("R1 requests after reset", nreq, 0);
    chk("R1 writes after reset", nw, 0);
    hwr(L1H, 16'h0000);
    hwr(L1L, 16'h0020);
    chk("R1 no start on location write", nreq, 0);

    for (int f = 0; f < 2; f++) begin
      frame(12);
      chk("R2 write count", nw, 2);
      chk("R2 first index", w_a[0], 8'h05);
      chk("R2 first data", w_d[0], 16'h1234);
      chk("R2 second index", w_a[1], 8'hA5);
      chk("R2 second data", w_d[1], 16'hABCD);
      chk("R3 move write cycle 1", w_k[0], 3);
      chk("R3 move write cycle 2", w_k[1], 5);
      chk("R6 slots then halt", ngr, 6);
      chk("R7 restart address", fa, 24'h000020);
    end

    P = 3;
    frame(24);
    chk("R5 sparse grant write 1", w_k[0], 2 * P + 1);
    chk("R5 sparse grant write 2", w_k[1], 4 * P + 1);
    chk("R5 sparse grant data", w_d[1], 16'hABCD);
    chk("R5 sparse grant slots", ngr, 6);
    P = 1;

    hwr(L1H, 16'h0012);
    hwr(L1L, 16'h0041);
    for (int i = 0; i < 20; i++) begin
      int tv, th, vm, hm, c;
      vm = 255; hm = 254;
      if (i < 16) begin
        tv = i / 4;
        th = (i % 4 == 0) ? 0 : (i % 4 == 1) ? 6 : (i % 4 == 2) ? 20 : 38;
      end else if (i == 16) begin
        tv = 3; th = 10; vm = 0;
      end else if (i == 17) begin
        tv = 1; th = 48; hm = 14;
      end else if (i == 18) begin
        tv = 2; th = 4; vm = 2; hm = 6;
      end else begin
        tv = 0; th = 30; vm = 0; hm = 0;
      end
      mem[7'h20] = {8'(tv), 8'(th) | 8'h01};
      mem[7'h21] = {8'(vm), 8'(hm) & 8'hFE};
      mem[7'h23] = 16'(i * 16'h0111 + 1);
      c = 3;
      while (!hitf(c, tv, th, vm, hm) && c < 2000) c++;
      frame(c + 10);
      chk("R4 wait release cycle", w_k[0], c + 4);
      chk("R4 write data after wait", w_d[0], 16'(i * 16'h0111 + 1));
      chk("R3 slots wait plus move", gb, 5);
      chk("R6 total slots", ngr, 7);
      if (i == 0) chk("R9 split location address", fa, 24'h120040);
    end

    clr();
    hwr(L1H, 16'h0000);
    hwr(L1L, 16'h0080);
    idle(8);
    chk("R9 location write leaves fetch idle", nreq, 0);
    frame(10);
    chk("R9 new location used", w_a[0], 8'h07);
    chk("R9 new location data", w_d[0], 16'h00BB);

    hwr(L1L, 16'h0020);
    hwr(L2L, 16'h00C0);
    k = 0; clr();
    hwr(J2, 16'h0);
    idle(12);
    chk("R4 stalled wait no write", nw, 0);
    chk("R4 stalled wait slots", ngr, 2);
    clr();
    begin
      int j;
      j = k;
      hwr(J1, 16'h0);
      idle(8);
      chk("R8 jump1 target", w_a[0], 8'h05);
      chk("R8 jump1 timing", w_k[0], j + 3);
    end

    hwr(L2L, 16'h0080);
    clr();
    begin
      int j;
      j = k;
      hwr(J2, 16'h0);
      idle(8);
      chk("R8 jump2 target", w_a[0], 8'h07);
      chk("R8 jump2 timing", w_k[0], j + 3);
    end

    k = 0; clr();
    step(1'b1, 1'b1, J2, 16'h0);
    idle(8);
    chk("R8 frame start wins", w_a[0], 8'h05);
    chk("R8 frame start wins timing", w_k[0], 3);

    en_nxt = 0;
    frame(20);
    chk("R10 no request disabled", nreq, 0);
    chk("R10 no write disabled", nw, 0);
    en_nxt = 1;
    clr();
    begin
      int e;
      e = k;
      idle(8);
      chk("R10 resume timing", w_k[0], e + 2);
      chk("R10 resume target", w_a[0], 8'h05);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule